// File: doc/BRIEF.md
# Four-level nested interrupt controller

This block sits beside a small CPU core and decides which of its interrupt request lines is served next. Each source has its own enable bit, and one global enable bit masks all of them at once. Each source also carries a two-bit preemption level built from two independent register bits: a low-weight bit and a high-weight bit. Level 3 is the most urgent and level 0 the least urgent.

Arbitration happens only when the CPU signals an instruction boundary. The block then picks one request. A higher level always beats a lower level. Among requests at the same level, the lowest source index wins. A request can only be taken if its level is strictly above every level currently in service.

The chosen request is raised to the CPU together with its source index. Both are held unchanged until the CPU acknowledges. An acknowledge marks the request's level as in service. A return strobe retires the most urgent level in service, so routines nest and unwind the way a stack does.

Top module: `nest_intc`

## Requirements
- R1: After a synchronous active-high reset, `cpu_irq` is 0, `cpu_vec` is 0 and no level is in service, so any enabled request at any level can be taken at the next boundary.
- R2: The level of source i is {`pri_hi[i]`, `pri_lo[i]`}, a value from 0 to 3, with 3 the most urgent. When eligible requests of different levels are pending, the one with the greatest level wins.
- R3: Among eligible requests of equal level, the source with the lowest index wins. This ranking only breaks ties; it never overrides a level difference.
- R4: Source i is eligible only when `req_in[i]`, `src_en[i]` and `glb_en` are all 1. With `glb_en` at 0, no boundary raises `cpu_irq`.
- R5: A winner is sampled only in a cycle with `insn_bnd` at 1, and `cpu_irq` rises at the next clock edge. While `cpu_irq` is 1, changes to the request lines, the enables, the priority bits or further boundary pulses leave `cpu_irq` and `cpu_vec` unchanged.
- R6: `irq_ack` while `cpu_irq` is 1 drops `cpu_irq` at the next edge and marks the winner's level as in service. `irq_ack` while `cpu_irq` is 0 has no effect.
- R7: While levels are in service, only a request whose level is strictly greater than the most urgent in-service level can be taken. Requests at an equal or lower level wait.
- R8: While level 3 is in service, no source is taken at all.
- R9: `irq_ret` retires only the most urgent level in service. The levels below it stay in service and keep blocking requests of their own level or lower.
- R10: `cpu_vec` holds the index, counted from 0, of the winning source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | N_SRC | Interrupt request lines, one per source |
| src_en | input | N_SRC | Per-source enable |
| glb_en | input | 1 | Global enable; 0 masks all sources |
| pri_lo | input | N_SRC | Low-weight level bit per source |
| pri_hi | input | N_SRC | High-weight level bit per source |
| insn_bnd | input | 1 | Instruction-boundary strobe; arbitration is sampled here |
| irq_ack | input | 1 | CPU accepts the pending request |
| irq_ret | input | 1 | Return from the current service routine |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | VEC_W | Index of the requesting source |

## Verification
The bench targets tie-breaking inside a level while a lower-index source sits at a lower level. A design that ranks by index first would hand the vector to the wrong source in that case.

It also tests equal-level preemption. A comparison using "greater or equal" would let a same-level source interrupt a routine that is already running.

It checks the return path with two or three levels stacked. A design that clears every in-service bit would unblock lower-level requests too early, and one that clears the lowest bit would keep the outer routine blocked.

Finally, it changes the request lines and pulses extra boundaries while a request awaits acknowledge. A design that re-arbitrates in that window would change `cpu_vec` under the CPU.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int CEIL_W  = LVL_W + 1;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [CEIL_W-1:0]  ceil_t;
  typedef logic [NUM_LVL-1:0] lvl_mask_t;
endpackage

// File: rtl/nest_intc_src.sv
// Per-source qualification and level assembly.
module nest_intc_src
  import nest_intc_pkg::*;
#(
  parameter int N_SRC = 10
) (
  input  logic [N_SRC-1:0]            req_in,
  input  logic [N_SRC-1:0]            src_en,
  input  logic                        glb_en,
  input  logic [N_SRC-1:0]            pri_lo,
  input  logic [N_SRC-1:0]            pri_hi,
  output logic [N_SRC-1:0]            elig,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign elig[g] = req_in[g] & src_en[g] & glb_en;
    assign lvl[g]  = {pri_hi[g], pri_lo[g]};
  end
endmodule

// File: rtl/nest_intc_arb.sv
// Picks the highest level at or above the ceiling; lowest index wins ties.
module nest_intc_arb
  import nest_intc_pkg::*;
#(
  parameter int N_SRC = 10,
  parameter int VEC_W = 4
) (
  input  logic [N_SRC-1:0]            elig,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  input  ceil_t                       ceil,
  output logic                        hit,
  output logic [VEC_W-1:0]            idx,
  output lvl_t                        win_lvl
);
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    // Scan downward; ">=" lets a lower index replace an equal-level holder.
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && ({1'b0, lvl[i]} >= ceil) && (!hit || lvl[i] >= win_lvl)) begin
        hit     = 1'b1;
        idx     = VEC_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/nest_intc_svc.sv
// In-service level stack: set on acknowledge, retire top on return.
module nest_intc_svc
  import nest_intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  lvl_t      push_lvl,
  input  logic      pop,
  output ceil_t     ceil,
  output lvl_mask_t active
);
  lvl_mask_t top_bit;
  lvl_mask_t push_bit;

  always_comb begin
    ceil    = '0;
    top_bit = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (active[l]) begin
        ceil    = CEIL_W'(l + 1);
        top_bit = lvl_mask_t'(1) << l;
      end
    end
    push_bit = lvl_mask_t'(1) << push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) active <= '0;
    else     active <= (active & ~(pop ? top_bit : '0)) | (push ? push_bit : '0);
  end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_intc_pkg::*;
#(
  parameter int N_SRC = 10,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_in,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] pri_lo,
  input  logic [N_SRC-1:0] pri_hi,
  input  logic             insn_bnd,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             cpu_irq,
  output logic [VEC_W-1:0] cpu_vec
);
  logic [N_SRC-1:0]            elig;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  ceil_t                       svc_ceil;
  lvl_mask_t                   svc_active;
  logic                        arb_hit;
  logic [VEC_W-1:0]            arb_idx;
  lvl_t                        arb_lvl;
  lvl_t                        pend_lvl;
  logic                        take;
  logic                        ack_ok;

  nest_intc_src #(.N_SRC(N_SRC)) u_src (
    .req_in(req_in), .src_en(src_en), .glb_en(glb_en),
    .pri_lo(pri_lo), .pri_hi(pri_hi), .elig(elig), .lvl(lvl)
  );

  nest_intc_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .elig(elig), .lvl(lvl), .ceil(svc_ceil),
    .hit(arb_hit), .idx(arb_idx), .win_lvl(arb_lvl)
  );

  assign take   = insn_bnd & ~cpu_irq & arb_hit;
  assign ack_ok = irq_ack & cpu_irq;

  nest_intc_svc u_svc (
    .clk(clk), .rst(rst), .push(ack_ok), .push_lvl(pend_lvl),
    .pop(irq_ret), .ceil(svc_ceil), .active(svc_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq  <= 1'b0;
      cpu_vec  <= '0;
      pend_lvl <= '0;
    end else if (ack_ok) begin
      cpu_irq  <= 1'b0;
    end else if (take) begin
      cpu_irq  <= 1'b1;
      cpu_vec  <= arb_idx;
      pend_lvl <= arb_lvl;
    end
  end
endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk #(
  parameter int N_SRC = 10,
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             insn_bnd,
  input logic             irq_ack,
  input logic             cpu_irq,
  input logic [VEC_W-1:0] cpu_vec,
  input logic [3:0]       svc_active
);
  // R5: request only rises after a boundary
  a_r5_rise_on_bnd: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> $past(insn_bnd));
  // R5: held steady until acknowledged
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && !irq_ack) |=> (cpu_irq && $stable(cpu_vec)));
  // R6: acknowledge drops the request
  a_r6_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && irq_ack) |=> !cpu_irq);
  // R6: acknowledge leaves at least one level in service
  a_r6_ack_marks: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && irq_ack) |=> (svc_active != 4'b0000));
  // R4: no request without global enable
  a_r4_glb: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> $past(glb_en));
  // R10: vector names an existing source
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (int'(cpu_vec) < N_SRC));
endmodule

bind nest_intc nest_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .insn_bnd(insn_bnd),
  .irq_ack(irq_ack), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
  .svc_active(svc_active)
);

// File: tb/nest_intc_tb.sv
`timescale 1ns/1ps
module nest_intc_tb;
  localparam int N = 10;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_in = '0, src_en = '0, pri_lo = '0, pri_hi = '0;
  logic glb_en = 1'b0, insn_bnd = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic cpu_irq;
  logic [VW-1:0] cpu_vec;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_mask = '0;   // bench model of in-service levels
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  nest_intc #(.N_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .req_in(req_in), .src_en(src_en), .glb_en(glb_en),
    .pri_lo(pri_lo), .pri_hi(pri_hi), .insn_bnd(insn_bnd), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // Expected winner from the requirements; -1 when none qualifies.
  function automatic int model_win(output int wl);
    int floor_lvl = 0;
    int best = -1;
    wl = -1;
    for (int l = 0; l < 4; l++) if (m_mask[l]) floor_lvl = l + 1;
    for (int i = 0; i < N; i++) begin
      int lv = 2 * int'(pri_hi[i]) + int'(pri_lo[i]);
      if (req_in[i] && src_en[i] && glb_en && lv >= floor_lvl && lv > wl) begin
        best = i; wl = lv;
      end
    end
    return best;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse a boundary and compare the outcome against the model.
  task automatic boundary(input string req, output int wl, output int w);
    w = model_win(wl);
    @(negedge clk) insn_bnd = 1'b1;
    @(negedge clk) insn_bnd = 1'b0;
    check({req, " irq"}, int'(cpu_irq), (w >= 0) ? 1 : 0);
    if (w >= 0) check({req, " vec"}, int'(cpu_vec), w);
  endtask

  task automatic ack(input int wl);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R6 ack drops", int'(cpu_irq), 0);
    m_mask[wl] = 1'b1;
  endtask

  task automatic ret();
    @(negedge clk) irq_ret = 1'b1;
    @(negedge clk) irq_ret = 1'b0;
    for (int l = 3; l >= 0; l--) if (m_mask[l]) begin m_mask[l] = 1'b0; break; end
  endtask

  task automatic set_lvl(input int i, input int lv);
    pri_hi[i] = lv[1]; pri_lo[i] = lv[0];
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w, wl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset irq", int'(cpu_irq), 0);
    check("R1 reset vec", int'(cpu_vec), 0);

    // R1 / R2: nothing in service, level-0 request taken
    glb_en = 1; src_en = '1;
    req_in = 10'b00_0000_1000;
    boundary("R1 empty service", wl, w);
    ack(wl); ret();

    // R2 + R3: index 1 at level 1, index 4 and 7 at level 2 -> 4 wins
    set_lvl(1, 1); set_lvl(4, 2); set_lvl(7, 2);
    req_in = '0; req_in[1] = 1; req_in[4] = 1; req_in[7] = 1;
    boundary("R2 R3 level then index", wl, w);
    check("R3 expect idx4", int'(cpu_vec), 4);

    // R5: held while pending despite input changes and extra boundaries
    req_in = '0; req_in[9] = 1; set_lvl(9, 3);
    @(negedge clk) insn_bnd = 1;
    @(negedge clk) insn_bnd = 0;
    check("R5 hold irq", int'(cpu_irq), 1);
    check("R5 hold vec", int'(cpu_vec), 4);
    ack(2);
    // R7: level 2 in service; level 3 (idx 9) preempts
    boundary("R7 higher preempts", wl, w);
    check("R7 idx9", int'(cpu_vec), 9);
    ack(wl);
    // R8: level 3 in service blocks everything
    src_en = '1; req_in = '1;
    boundary("R8 top blocks", wl, w);
    check("R8 none", int'(cpu_irq), 0);
    // R9: return retires level 3 only; level-2 request still blocked
    ret();
    req_in = '0; req_in[7] = 1;
    boundary("R9 lower still blocked", wl, w);
    check("R9 blocked", int'(cpu_irq), 0);
    ret();
    boundary("R9 unblocked", wl, w);
    check("R9 idx7", int'(cpu_vec), 7);
    ack(wl); ret();

    // R4: global enable and source enable masks
    glb_en = 0; req_in = '1;
    boundary("R4 global off", wl, w);
    glb_en = 1; src_en = '0;
    boundary("R4 sources off", wl, w);
    src_en = '1;

    // R5: no boundary, no request
    req_in = 10'b00_0000_0001;
    repeat (4) @(negedge clk);
    check("R5 no boundary", int'(cpu_irq), 0);

    // R6: stray ack without pending request changes nothing
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    check("R6 stray ack", int'(cpu_irq), 0);
    boundary("R6 stray ack no marking", wl, w);
    ack(wl); ret();

    // Sweep: random patterns with live nesting (R2 R3 R4 R7 R8 R9 R10)
    for (int it = 0; it < 3000; it++) begin
      rng = nxt(rng); req_in = rng[9:0]; src_en = rng[19:10];
      glb_en = (rng[23:20] != 0);
      rng = nxt(rng); pri_lo = rng[9:0]; pri_hi = rng[19:10];
      boundary("R10 sweep", wl, w);
      if (w >= 0) ack(wl);
      if (rng[22:21] == 2'b00 || m_mask == 4'hF) ret();
    end
    while (m_mask != 0) ret();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule